// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a complete processor that fetches, decodes and executes one 32-bit instruction in every clock cycle. It holds a byte-addressed program counter, a small read-only program store, a 32-entry register file, a main decoder, an arithmetic/logic unit and a word-wide read/write data store. All of these are kept in separate address spaces. Every operation, including the register-to-register ones, is selected only by the 6-bit field in bits [31:26]. No secondary function field exists.

The program store and data store carry no loading logic. A testbench or a system integrator fills them by hierarchical initialisation before reset is released. The only external access is a debug read port on the register file. It returns the content of one register, registered, one clock after the index is presented. Pipelining, hazards, traps, interrupts and sub-word memory accesses are outside this block.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter is set to 0 on that edge, and no register-file or data-store write takes place. After `rst` falls, the instruction in program word 0 executes first.
- R2: Register 0 reads as zero on every read port, and any instruction targeting it leaves it at zero.
- R3: add (000000), sub (001000), addu (001001) and subu (001010) write rs+rt or rs-rt modulo 2^32 to rd. The signed and unsigned forms give identical bits and never trap.
- R4: addi (000001) and addiu (001011) write rs + sign-extended imm[15:0] to rt. andi (001110) and ori (001111) combine rs with the zero-extended immediate.
- R5: and (001100) and or (001101) write the bitwise AND/OR of rs and rt to rd.
- R6: sll (000010) writes rt shifted left by shamt (bits [10:6]) to rd, filling with zeros.
- R7: slt (000011) writes 1 to rd when rs < rt as signed two's-complement values, and 0 otherwise.
- R8: sw (000100) stores rt and lw (000101) loads rt at byte address rs + sign-extended imm. The word selected is address bits [11:2].
- R9: beq (000110) branches when rs equals rt, and bne (010000) branches when they differ. A taken branch moves the PC to PC+4 + (sign-extended imm << 2), which may point backwards. An untaken branch, or any non-control instruction, moves it to PC+4.
- R10: j (000111) sets the PC to {PC+4[31:28], bits[25:0], 2'b00}.
- R11: An opcode outside the defined set writes neither the register file nor the data store, and the PC advances by 4.
- R12: `dbg_data` is 0 while in reset. Otherwise, one clock after `dbg_addr` is presented, it shows the content of that register, and index 0 shows zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_addr | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Registered content of the register chosen by `dbg_addr` |

## Verification
Several rules are checked on every cycle by the assertions:
- the PC returning to zero under reset;
- the PC advancing by four after any non-control instruction;
- the PC target of a taken beq and of j;
- register 0 reading zero;
- undefined opcodes never raising a write enable;
- the debug port returning zero for index 0.

The arithmetic and logic results, the sign or zero extension of immediates, the shifts, the signed comparison, the store-then-load round trip through the data store, and the suppression of writes while reset is held can only be shown by the bench's program. That program writes values into registers that are then read back through the debug port. Untaken branches and the skipped instructions after taken branches and jumps are also visible only there, through registers that must stay at zero.

// File: rtl/sc_pkg.sv
package sc_pkg;

  typedef enum logic [5:0] {
    OP_ADD   = 6'b000000,
    OP_ADDI  = 6'b000001,
    OP_SLL   = 6'b000010,
    OP_SLT   = 6'b000011,
    OP_SW    = 6'b000100,
    OP_LW    = 6'b000101,
    OP_BEQ   = 6'b000110,
    OP_J     = 6'b000111,
    OP_SUB   = 6'b001000,
    OP_ADDU  = 6'b001001,
    OP_SUBU  = 6'b001010,
    OP_ADDIU = 6'b001011,
    OP_AND   = 6'b001100,
    OP_OR    = 6'b001101,
    OP_ANDI  = 6'b001110,
    OP_ORI   = 6'b001111,
    OP_BNE   = 6'b010000
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLL = 3'd4,
    ALU_SLT = 3'd5
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;   // write-back enable
    logic    dst_rd;      // 1: destination is rd, 0: rt
    logic    use_imm;     // ALU operand B from immediate
    logic    imm_zext;    // zero-extend the immediate
    logic    mem_write;   // store to data memory
    logic    mem_to_reg;  // write-back from data memory
    logic    br_eq;       // branch when equal
    logic    br_ne;       // branch when not equal
    logic    jump;        // absolute jump
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OP_ADD, OP_ADDU: begin
        ctrl.reg_write = 1'b1;
        ctrl.dst_rd    = 1'b1;
        ctrl.alu_op    = ALU_ADD;
      end
      OP_SUB, OP_SUBU: begin
        ctrl.reg_write = 1'b1;
        ctrl.dst_rd    = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      OP_AND: begin
        ctrl.reg_write = 1'b1;
        ctrl.dst_rd    = 1'b1;
        ctrl.alu_op    = ALU_AND;
      end
      OP_OR: begin
        ctrl.reg_write = 1'b1;
        ctrl.dst_rd    = 1'b1;
        ctrl.alu_op    = ALU_OR;
      end
      OP_SLT: begin
        ctrl.reg_write = 1'b1;
        ctrl.dst_rd    = 1'b1;
        ctrl.alu_op    = ALU_SLT;
      end
      OP_SLL: begin
        ctrl.reg_write = 1'b1;
        ctrl.dst_rd    = 1'b1;
        ctrl.alu_op    = ALU_SLL;
      end
      OP_ADDI, OP_ADDIU: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
        ctrl.alu_op    = ALU_ADD;
      end
      OP_ANDI: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
        ctrl.imm_zext  = 1'b1;
        ctrl.alu_op    = ALU_AND;
      end
      OP_ORI: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
        ctrl.imm_zext  = 1'b1;
        ctrl.alu_op    = ALU_OR;
      end
      OP_LW: begin
        ctrl.reg_write  = 1'b1;
        ctrl.use_imm    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.alu_op     = ALU_ADD;
      end
      OP_SW: begin
        ctrl.use_imm   = 1'b1;
        ctrl.mem_write = 1'b1;
        ctrl.alu_op    = ALU_ADD;
      end
      OP_BEQ: begin
        ctrl.br_eq  = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_BNE: begin
        ctrl.br_ne  = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_J: begin
        ctrl.jump = 1'b1;
      end
      default: ctrl = '0;  // undefined opcode: behaves as a no-op
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [4:0]      shamt,
  output logic [XLEN-1:0] y,
  output logic            eq
);

  logic lt_signed;

  assign lt_signed = $signed(a) < $signed(b);
  assign eq        = (a == b);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLL: y = b << shamt;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, lt_signed};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RA_W = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RA_W-1:0] ra1,
  input  logic [RA_W-1:0] ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            we,
  input  logic [RA_W-1:0] wa,
  input  logic [XLEN-1:0] wd,
  input  logic [RA_W-1:0] dbg_ra,
  output logic [XLEN-1:0] dbg_rd
);

  logic [XLEN-1:0] regs [NREGS];

  initial begin
    for (int i = 0; i < NREGS; i++) regs[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  always_ff @(posedge clk) begin
    if (rst)                 dbg_rd <= '0;
    else if (dbg_ra == '0)   dbg_rd <= '0;
    else                     dbg_rd <= regs[dbg_ra];
  end

endmodule

// File: rtl/sc_mem.sv
module sc_imem #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0]   word_idx,
  output logic [XLEN-1:0] rdata
);

  logic [XLEN-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) rom[i] = '0;
  end

  assign rdata = rom[word_idx];

endmodule

module sc_dmem #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   word_idx,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata
);

  logic [XLEN-1:0] ram [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) ram[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) ram[word_idx] <= wdata;
  end

  assign rdata = ram[word_idx];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREGS      = 32,
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  dbg_addr,
  output logic [31:0] dbg_data
);

  localparam int IA_W = $clog2(IMEM_DEPTH);
  localparam int DA_W = $clog2(DMEM_DEPTH);
  localparam int RA_W = $clog2(NREGS);
  localparam int JT_W = 26;

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, j_target;
  logic [XLEN-1:0] instr;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, imm_ext, wb_data, dm_rdata;
  logic [RA_W-1:0] f_rs, f_rt, f_rd, wr_addr;
  logic [4:0]      f_shamt;
  logic [15:0]     f_imm;
  logic            alu_eq, br_taken, rf_we, dm_we;
  ctrl_t           ctrl;

  // Program counter
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {{(XLEN-18){f_imm[15]}}, f_imm, 2'b00};
  assign j_target  = {pc_plus4[XLEN-1:JT_W+2], instr[JT_W-1:0], 2'b00};
  assign br_taken  = (ctrl.br_eq & alu_eq) | (ctrl.br_ne & ~alu_eq);
  assign pc_next   = ctrl.jump ? j_target : (br_taken ? br_target : pc_plus4);

  // Fetch
  sc_imem #(.XLEN(XLEN), .DEPTH(IMEM_DEPTH)) u_imem (
    .word_idx (pc_q[IA_W+1:2]),
    .rdata    (instr)
  );

  // Field split
  assign f_rs    = instr[25:21];
  assign f_rt    = instr[20:16];
  assign f_rd    = instr[15:11];
  assign f_shamt = instr[10:6];
  assign f_imm   = instr[15:0];

  sc_decoder u_dec (
    .opcode (instr[31:26]),
    .ctrl   (ctrl)
  );

  // Register file
  assign wr_addr = ctrl.dst_rd ? f_rd : f_rt;
  assign rf_we   = ctrl.reg_write & ~rst;
  assign wb_data = ctrl.mem_to_reg ? dm_rdata : alu_y;

  sc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .ra1    (f_rs),
    .ra2    (f_rt),
    .rd1    (rs_val),
    .rd2    (rt_val),
    .we     (rf_we),
    .wa     (wr_addr),
    .wd     (wb_data),
    .dbg_ra (dbg_addr),
    .dbg_rd (dbg_data)
  );

  // Execute
  assign imm_ext = ctrl.imm_zext ? {{(XLEN-16){1'b0}}, f_imm}
                                 : {{(XLEN-16){f_imm[15]}}, f_imm};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .op    (ctrl.alu_op),
    .a     (rs_val),
    .b     (alu_b),
    .shamt (f_shamt),
    .y     (alu_y),
    .eq    (alu_eq)
  );

  // Data memory
  assign dm_we = ctrl.mem_write & ~rst;

  sc_dmem #(.XLEN(XLEN), .DEPTH(DMEM_DEPTH)) u_dmem (
    .clk      (clk),
    .we       (dm_we),
    .word_idx (alu_y[DA_W+1:2]),
    .wdata    (rt_val),
    .rdata    (dm_rdata)
  );

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        rf_we,
  input logic        dm_we,
  input logic [4:0]  dbg_addr,
  input logic [31:0] dbg_data
);

  logic [5:0]  op;
  logic        is_ctrl, is_defined;
  logic [31:0] exp_br, exp_j;

  assign op      = instr[31:26];
  assign is_ctrl = (op == OP_BEQ) || (op == OP_BNE) || (op == OP_J);
  assign is_defined = (op <= 6'b001111) || (op == OP_BNE);
  assign exp_br  = pc + 32'd4 + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign exp_j   = {pc[31:28] + ((pc[27:0] >= 28'hFFFFFFC) ? 4'd1 : 4'd0),
                    instr[25:0], 2'b00};

  a_r1_reset_pc: assert property (@(posedge clk) rst |=> pc == 32'd0);

  a_r2_zero_read: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));

  a_r9_sequential: assert property (@(posedge clk) disable iff (rst)
    !is_ctrl |=> pc == $past(pc) + 32'd4);

  a_r9_beq_taken: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BEQ && rs_val == rt_val) |=> pc == $past(exp_br));

  a_r10_jump: assert property (@(posedge clk) disable iff (rst)
    (op == OP_J) |=> pc == $past(exp_j));

  a_r11_no_write: assert property (@(posedge clk) disable iff (rst)
    !is_defined |-> (!rf_we && !dm_we));

  a_r12_dbg_zero: assert property (@(posedge clk) disable iff (rst)
    (dbg_addr == 5'd0) |=> dbg_data == 32'd0);

endmodule

bind sc_core sc_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc_q),
  .instr    (instr),
  .rs_val   (rs_val),
  .rt_val   (rt_val),
  .rf_we    (rf_we),
  .dm_we    (dm_we),
  .dbg_addr (dbg_addr),
  .dbg_data (dbg_data)
);

// File: tb/test_sc_core.sv
module test_sc_core;

  localparam int CLK_PERIOD = 10;
  localparam int NEXP = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  dbg_addr = 5'd0;
  logic [31:0] dbg_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core i_sc_core (
    .clk      (clk),
    .rst      (rst),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  // {requirement code, register, expected value}
  localparam logic [40:0] EXP [NEXP] = '{
    {4'd4,  5'd1,  32'h0000_0005},
    {4'd4,  5'd2,  32'hFFFF_FFFD},
    {4'd3,  5'd3,  32'h0000_0002},
    {4'd3,  5'd4,  32'h0000_0008},
    {4'd3,  5'd5,  32'hFFFF_FFFA},
    {4'd3,  5'd6,  32'hFFFF_FFF8},
    {4'd4,  5'd7,  32'hFFFF_8000},
    {4'd4,  5'd8,  32'h0000_F0F0},
    {4'd4,  5'd9,  32'h0000_8001},
    {4'd5,  5'd10, 32'h0000_8001},
    {4'd5,  5'd11, 32'h0000_8005},
    {4'd6,  5'd12, 32'h0000_0050},
    {4'd7,  5'd13, 32'h0000_0001},
    {4'd7,  5'd14, 32'h0000_0000},
    {4'd8,  5'd15, 32'h0000_0008},
    {4'd8,  5'd16, 32'hFFFF_8000},
    {4'd2,  5'd17, 32'h0000_0000},
    {4'd9,  5'd18, 32'h0000_0000},
    {4'd9,  5'd19, 32'h0000_0003},
    {4'd9,  5'd20, 32'h0000_0000},
    {4'd9,  5'd21, 32'h0000_0006},
    {4'd11, 5'd22, 32'h0000_0000},
    {4'd10, 5'd23, 32'h0000_0000},
    {4'd2,  5'd0,  32'h0000_0000}
  };

  function automatic string req_name(input logic [3:0] code);
    case (code)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      4'd11: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [31:0] enc_r(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd,
                                        input logic [4:0] sh);
    return {op, rs, rt, rd, sh, 6'd0};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk) dbg_addr = a;
    @(negedge clk) v = dbg_data;
  endtask

  task automatic load_program;
    i_sc_core.u_imem.rom[0]  = enc_i(6'b000001, 5'd0, 5'd1, 16'd5);       // addi r1
    i_sc_core.u_imem.rom[1]  = enc_i(6'b000001, 5'd0, 5'd2, 16'hFFFD);    // addi r2=-3
    i_sc_core.u_imem.rom[2]  = enc_r(6'b000000, 5'd1, 5'd2, 5'd3, 5'd0);  // add
    i_sc_core.u_imem.rom[3]  = enc_r(6'b001000, 5'd1, 5'd2, 5'd4, 5'd0);  // sub
    i_sc_core.u_imem.rom[4]  = enc_r(6'b001001, 5'd2, 5'd2, 5'd5, 5'd0);  // addu
    i_sc_core.u_imem.rom[5]  = enc_r(6'b001010, 5'd2, 5'd1, 5'd6, 5'd0);  // subu
    i_sc_core.u_imem.rom[6]  = enc_i(6'b001011, 5'd0, 5'd7, 16'h8000);    // addiu
    i_sc_core.u_imem.rom[7]  = enc_i(6'b001110, 5'd2, 5'd8, 16'hF0F0);    // andi
    i_sc_core.u_imem.rom[8]  = enc_i(6'b001111, 5'd0, 5'd9, 16'h8001);    // ori
    i_sc_core.u_imem.rom[9]  = enc_r(6'b001100, 5'd2, 5'd9, 5'd10, 5'd0); // and
    i_sc_core.u_imem.rom[10] = enc_r(6'b001101, 5'd1, 5'd9, 5'd11, 5'd0); // or
    i_sc_core.u_imem.rom[11] = enc_r(6'b000010, 5'd0, 5'd1, 5'd12, 5'd4); // sll
    i_sc_core.u_imem.rom[12] = enc_r(6'b000011, 5'd2, 5'd1, 5'd13, 5'd0); // slt -3<5
    i_sc_core.u_imem.rom[13] = enc_r(6'b000011, 5'd1, 5'd2, 5'd14, 5'd0); // slt 5<-3
    i_sc_core.u_imem.rom[14] = enc_i(6'b000100, 5'd0, 5'd4, 16'd16);      // sw r4,16(r0)
    i_sc_core.u_imem.rom[15] = enc_i(6'b000100, 5'd12, 5'd7, 16'hFFFC);   // sw r7,-4(r12)
    i_sc_core.u_imem.rom[16] = enc_i(6'b000101, 5'd0, 5'd15, 16'd16);     // lw
    i_sc_core.u_imem.rom[17] = enc_i(6'b000101, 5'd0, 5'd16, 16'd76);     // lw
    i_sc_core.u_imem.rom[18] = enc_i(6'b000001, 5'd0, 5'd0, 16'd77);      // addi r0
    i_sc_core.u_imem.rom[19] = enc_r(6'b000000, 5'd0, 5'd0, 5'd17, 5'd0); // add r17=r0+r0
    i_sc_core.u_imem.rom[20] = enc_i(6'b000110, 5'd1, 5'd1, 16'd2);       // beq taken
    i_sc_core.u_imem.rom[21] = enc_i(6'b000001, 5'd0, 5'd18, 16'd1);
    i_sc_core.u_imem.rom[22] = enc_i(6'b000001, 5'd0, 5'd18, 16'd2);
    i_sc_core.u_imem.rom[23] = enc_i(6'b000110, 5'd1, 5'd2, 16'd1);       // beq not taken
    i_sc_core.u_imem.rom[24] = enc_i(6'b000001, 5'd0, 5'd19, 16'd3);
    i_sc_core.u_imem.rom[25] = enc_i(6'b010000, 5'd1, 5'd2, 16'd1);       // bne taken
    i_sc_core.u_imem.rom[26] = enc_i(6'b000001, 5'd0, 5'd20, 16'd4);
    i_sc_core.u_imem.rom[27] = enc_i(6'b010000, 5'd1, 5'd1, 16'd1);       // bne not taken
    i_sc_core.u_imem.rom[28] = enc_i(6'b000001, 5'd0, 5'd21, 16'd6);
    i_sc_core.u_imem.rom[29] = enc_r(6'b111111, 5'd1, 5'd22, 5'd22, 5'd0); // undefined
    i_sc_core.u_imem.rom[30] = {6'b000111, 26'd33};                        // j 33
    i_sc_core.u_imem.rom[31] = enc_i(6'b000001, 5'd0, 5'd23, 16'd9);
    i_sc_core.u_imem.rom[32] = enc_i(6'b000001, 5'd0, 5'd23, 16'd10);
    i_sc_core.u_imem.rom[33] = enc_i(6'b000110, 5'd0, 5'd0, 16'hFFFF);    // backward self-loop
  endtask

  initial begin
    logic [31:0] v;
    #1 load_program();
    repeat (3) @(negedge clk);
    check("R12", dbg_data, 32'd0);          // reset state of debug port
    rst = 1'b0;
    repeat (60) @(negedge clk);

    for (int k = 0; k < NEXP; k++) begin
      read_reg(EXP[k][36:32], v);
      check(req_name(EXP[k][40:37]), v, EXP[k][31:0]);
    end

    // R1: reset holds writes off and restarts at word 0
    @(negedge clk) rst = 1'b1;
    i_sc_core.u_imem.rom[0] = enc_i(6'b000001, 5'd24, 5'd24, 16'd1);      // r24 += 1
    repeat (6) @(negedge clk);
    check("R1", dbg_data, 32'd0);
    rst = 1'b0;
    repeat (60) @(negedge clk);
    read_reg(5'd24, v);
    check("R1", v, 32'd1);
    read_reg(5'd3, v);
    check("R3", v, 32'd2);
    read_reg(5'd21, v);
    check("R9", v, 32'd6);
    read_reg(5'd0, v);
    check("R2", v, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule